// File: doc/BRIEF.md
# I2C Target Byte Engine

This block is the byte-level serial engine of an I2C target port. It watches the SCL and SDA lines, finds START and STOP conditions, and moves bytes most significant bit first through a single 9-stage path: eight data stages and one acknowledge stage. Receive and transmit share this path. Every bit the block sends is sampled back from the bus, so the data register always holds the byte that was actually on the wires. The acknowledge stage is controlled by the hardware only and cannot be reached from the CPU side.

After a START, the first byte is checked against a programmable 7-bit own address and, if enabled, against the general-call address 0x00. A matching write address is acknowledged and the block receives data. A matching read address moves the block into target-transmit mode, where it drives the data register contents onto the bus. When a byte and its acknowledge have finished, an interrupt flag is raised. The block then holds SCL low until software clears the flag. While the flag is set, software reads or replaces the data register. A host-mode input disables the address compare, because the own address has no meaning while the port acts as a controller.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, both line drives are released, the flag, `addr_hit`, `gc_hit` and `slave_tx` are 0, and `cpu_rdata` is 0x00.
- R2: The own-address register keeps the address in bits [7:1] and the general-call enable in bit 0. A first byte whose bits [7:1] equal the own address is acknowledged (SDA low during the ninth pulse) when `ack_en` is 1. It then raises the flag and sets `addr_hit` to 1 and `gc_hit` to 0.
- R3: A first byte whose address does not match gets no acknowledge (SDA high) and no flag. Later bytes up to the next START are also ignored in this way.
- R4: With the general-call enable set, a first byte of 0x00 is acknowledged, raises the flag and sets both `gc_hit` and `addr_hit`. With the enable clear, 0x00 gets no acknowledge and no flag.
- R5: With `ack_en` at 0, a matching address gets no acknowledge and no flag. A received data byte gets no acknowledge but still raises the flag.
- R6: Data bytes are sampled on SCL rising edges, MSB first. Once the flag is raised, the byte can be read on `cpu_rdata`, and with `ack_en` at 1 it was acknowledged.
- R7: While the flag is set, SCL is held low. The flag falls only on `irq_clr`, after which SCL is released. SDA is not driven while the flag is set.
- R8: `cpu_wr` loads `cpu_wdata` into the data register only while the flag is set. A write while the flag is clear is ignored.
- R9: A matching address with bit 0 set (read) sets `slave_tx`. After each flag clear, the block drives the data register MSB first, changing SDA only while SCL is low. On a controller NACK (SDA high in the ninth pulse), `slave_tx` goes to 0 and the block drives nothing more until the next START.
- R10: While transmitting, each bus bit is sampled back into the data register. A bit that the block leaves high but another driver pulls low is stored as 0.
- R11: A START, including one inside a byte, restarts the bit count and makes the next byte an address byte. A STOP returns the block to idle, with `addr_hit`, `gc_hit` and `slave_tx` at 0.
- R12: With `host_mode` at 1, no address matches: there is no acknowledge, no flag, and `addr_hit` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low (open-drain) |
| host_mode | input | 1 | Port acts as controller; address compare disabled |
| ack_en | input | 1 | Allow acknowledging addresses and data |
| own_wr | input | 1 | Write strobe for the own-address register |
| own_wdata | input | 8 | Address in [7:1], general-call enable in [0] |
| cpu_wr | input | 1 | Write strobe for the data register |
| cpu_wdata | input | 8 | Data register write value |
| cpu_rdata | output | 8 | Data register contents |
| irq | output | 1 | Byte-complete flag |
| irq_clr | input | 1 | Clears the flag |
| addr_hit | output | 1 | Own or general-call address matched |
| gc_hit | output | 1 | The match was a general call |
| slave_tx | output | 1 | Target-transmit mode active |

## Verification
The hardest state to reach from the ports is a transmit bit where the block releases SDA while the bus still shows a low. This only happens when a second driver contends on the line. The bench controller model pulls SDA low during one bit of a read transfer that the block sends as 1, then checks both the received byte and `cpu_rdata`. A START placed inside a partly shifted byte is reached in a similar way: the model stops after three bits and issues a new START before sending a full address.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_TX,
    ST_SKIP
  } eng_state_t;
endpackage

// File: rtl/i2cb_line_sync.sv
module i2cb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else if (g == 0) begin
          scl_ff[g] <= scl_i;
          sda_ff[g] <= sda_i;
        end else begin
          scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
          sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_ff[STAGES-1];
      sda_q <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cb_shifter.sv
module i2cb_shifter #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  input  logic          cnt_clr,
  input  logic          ld,
  input  logic [W-1:0]  ld_val,
  input  logic          sda_s,
  output logic [W-1:0]  data,
  output logic [CW-1:0] cnt,
  output logic          ack_bit
);
  localparam logic [CW-1:0] CNT_ACK = CW'(W);
  localparam logic [CW-1:0] CNT_END = CW'(W + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      data    <= '0;
      cnt     <= '0;
      ack_bit <= 1'b1;
    end else if (cnt_clr) begin
      cnt <= '0;
    end else if (ld) begin
      data <= ld_val;
    end else if (rise) begin
      if (cnt < CNT_ACK) begin
        data <= {data[W-2:0], sda_s};
        cnt  <= cnt + 1'b1;
      end else if (cnt == CNT_ACK) begin
        ack_bit <= sda_s;
        cnt     <= CNT_END;
      end
    end
  end
endmodule

// File: rtl/i2cb_addr_match.sv
module i2cb_addr_match #(
  parameter int AW = 7
) (
  input  logic [AW:0]   rx_byte,
  input  logic [AW-1:0] own,
  input  logic          gc_en,
  input  logic          host_mode,
  output logic          hit,
  output logic          gc,
  output logic          rd
);
  always_comb begin
    gc  = gc_en && !host_mode && (rx_byte == '0);
    hit = !host_mode && ((rx_byte[AW:1] == own) || gc);
    rd  = rx_byte[0];
  end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic              host_mode,
  input  logic              ack_en,
  input  logic              own_wr,
  input  logic [DATA_W-1:0] own_wdata,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              irq,
  input  logic              irq_clr,
  output logic              addr_hit,
  output logic              gc_hit,
  output logic              slave_tx
);
  import i2cb_pkg::*;

  localparam int ADDR_W = DATA_W - 1;
  localparam int CNT_W  = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_ACK = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DATA_W + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic              ack_bit;
  logic [ADDR_W-1:0] own_addr;
  logic              gc_en;
  logic              m_hit, m_gc, m_rd;
  logic              take, take_gc, take_rd;
  logic              sda_low;
  logic              fall8, fall9, fall_mid;
  eng_state_t        st;

  i2cb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign fall8    = scl_fall && (bit_cnt == CNT_ACK);
  assign fall9    = scl_fall && (bit_cnt == CNT_END);
  assign fall_mid = scl_fall && (bit_cnt != '0) && (bit_cnt < CNT_ACK);

  i2cb_shifter #(.W(DATA_W), .CW(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .rise(scl_rise),
    .cnt_clr(start_det | stop_det | fall9),
    .ld(cpu_wr & irq), .ld_val(cpu_wdata), .sda_s(sda_s),
    .data(shift_q), .cnt(bit_cnt), .ack_bit(ack_bit)
  );

  i2cb_addr_match #(.AW(ADDR_W)) u_match (
    .rx_byte(shift_q), .own(own_addr), .gc_en(gc_en), .host_mode(host_mode),
    .hit(m_hit), .gc(m_gc), .rd(m_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      own_addr <= '0;
      gc_en    <= 1'b0;
    end else if (own_wr) begin
      own_addr <= own_wdata[DATA_W-1:1];
      gc_en    <= own_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      sda_low  <= 1'b0;
      addr_hit <= 1'b0;
      gc_hit   <= 1'b0;
      slave_tx <= 1'b0;
      take     <= 1'b0;
      take_gc  <= 1'b0;
      take_rd  <= 1'b0;
    end else if (start_det || stop_det) begin
      st       <= start_det ? ST_ADDR : ST_IDLE;
      sda_low  <= 1'b0;
      addr_hit <= 1'b0;
      gc_hit   <= 1'b0;
      slave_tx <= 1'b0;
    end else begin
      if (irq && irq_clr && st == ST_TX)
        sda_low <= ~shift_q[DATA_W-1];
      if (fall_mid && st == ST_TX)
        sda_low <= ~shift_q[DATA_W-1];
      if (fall8) begin
        case (st)
          ST_ADDR: begin
            take    <= m_hit && ack_en;
            take_gc <= m_gc;
            take_rd <= m_rd;
            sda_low <= m_hit && ack_en;
          end
          ST_RX:   sda_low <= ack_en;
          default: sda_low <= 1'b0;
        endcase
      end
      if (fall9) begin
        sda_low <= 1'b0;
        case (st)
          ST_ADDR: begin
            if (take) begin
              addr_hit <= 1'b1;
              gc_hit   <= take_gc;
              slave_tx <= take_rd;
              st       <= take_rd ? ST_TX : ST_RX;
            end else begin
              st <= ST_SKIP;
            end
          end
          ST_TX: begin
            if (ack_bit) begin
              st       <= ST_SKIP;
              slave_tx <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq <= 1'b0;
    else if (fall9 && (st == ST_RX || st == ST_TX || (st == ST_ADDR && take)))
      irq <= 1'b1;
    else if (irq_clr)
      irq <= 1'b0;
  end

  assign scl_drive_low = irq;
  assign sda_drive_low = sda_low;
  assign cpu_rdata     = shift_q;
endmodule

// File: rtl/i2cb_engine_chk.sv
module i2cb_engine_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              irq_clr,
  input logic              cpu_wr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              addr_hit,
  input logic              gc_hit,
  input logic              slave_tx,
  input logic              sda_drive_low,
  input logic              host_mode
);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    irq && !irq_clr |=> irq);

  a_r7_sda_free_while_held: assert property (@(posedge clk) disable iff (rst)
    irq |-> !sda_drive_low);

  a_r8_data_stable: assert property (@(posedge clk) disable iff (rst)
    irq && !cpu_wr |=> $stable(cpu_rdata));

  a_r9_tx_needs_match: assert property (@(posedge clk) disable iff (rst)
    slave_tx |-> addr_hit);

  a_r4_gc_is_match: assert property (@(posedge clk) disable iff (rst)
    gc_hit |-> addr_hit);

  a_r12_no_match_as_host: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_hit) |-> !$past(host_mode));
endmodule

bind i2c_byte_engine i2cb_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .irq_clr(irq_clr), .cpu_wr(cpu_wr),
  .cpu_rdata(cpu_rdata), .addr_hit(addr_hit), .gc_hit(gc_hit),
  .slave_tx(slave_tx), .sda_drive_low(sda_drive_low), .host_mode(host_mode)
);

// File: tb/i2c_byte_engine_tb_top.sv
module i2c_byte_engine_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_drive_low, sda_drive_low;
  logic host_mode = 1'b0, ack_en = 1'b1;
  logic own_wr = 1'b0, cpu_wr = 1'b0, irq_clr = 1'b0;
  logic [7:0] own_wdata = '0, cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic irq, addr_hit, gc_hit, slave_tx;
  int n_chk = 0, n_fail = 0;

  wire scl_line = scl_m & ~scl_drive_low;
  wire sda_line = sda_m & ~sda_drive_low;

  always #10 clk = ~clk;

  i2c_byte_engine dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .host_mode(host_mode), .ack_en(ack_en), .own_wr(own_wr), .own_wdata(own_wdata),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .irq(irq), .irq_clr(irq_clr), .addr_hit(addr_hit), .gc_hit(gc_hit),
    .slave_tx(slave_tx)
  );

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl;
    while (!scl_line) tick(1);
  endtask

  task automatic clk_bit(input logic drv, output logic smp);
    sda_m = drv; tick(Q);
    scl_m = 1'b1; wait_scl; tick(Q);
    smp = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; wait_scl; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; wait_scl; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic flag_clear;
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(2);
  endtask

  task automatic cpu_write(input logic [7:0] v);
    cpu_wdata = v; cpu_wr = 1'b1; tick(1); cpu_wr = 1'b0; tick(1);
  endtask

  task automatic set_own(input logic [6:0] a, input logic gc);
    own_wdata = {a, gc}; own_wr = 1'b1; tick(1); own_wr = 1'b0; tick(1);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit hold_chk, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      if (i == 7 && hold_chk) begin
        sda_m = b[7]; tick(Q);
        scl_m = 1'b1; tick(Q);
        check("R7 scl held low while flag set", scl_line, 1'b0);
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(4);
        check("R7 scl released after clear", scl_line, 1'b1);
        wait_scl; tick(Q);
        scl_m = 1'b0; tick(Q);
      end else begin
        clk_bit(b[i], s);
      end
    end
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input logic give_ack, input logic [7:0] force_low, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(~force_low[i], s);
      b = {b[6:0], s};
    end
    clk_bit(~give_ack, s);
  endtask

  task automatic t_reset;
    check("R1 sda released", sda_drive_low, 1'b0);
    check("R1 scl released", scl_drive_low, 1'b0);
    check("R1 flag", irq, 1'b0);
    check("R1 data", cpu_rdata, 8'h00);
    check("R1 addr_hit", addr_hit, 1'b0);
    check("R1 slave_tx", slave_tx, 1'b0);
  endtask

  task automatic t_write_xfer;
    logic ak;
    set_own(7'h5A, 1'b0);
    bus_start;
    send_byte(8'hB4, 1'b0, ak);
    check("R2 address ack", ak, 1'b1);
    check("R2 flag", irq, 1'b1);
    check("R2 addr_hit", addr_hit, 1'b1);
    check("R2 gc_hit", gc_hit, 1'b0);
    check("R2 not tx", slave_tx, 1'b0);
    flag_clear;
    send_byte(8'h3C, 1'b0, ak);
    check("R6 data ack", ak, 1'b1);
    check("R6 flag", irq, 1'b1);
    check("R6 data value", cpu_rdata, 8'h3C);
    cpu_write(8'h99);
    check("R8 write while flag set", cpu_rdata, 8'h99);
    ack_en = 1'b0;
    send_byte(8'hC3, 1'b1, ak);
    check("R5 data nack", ak, 1'b0);
    check("R5 flag on nacked data", irq, 1'b1);
    check("R6 second data", cpu_rdata, 8'hC3);
    ack_en = 1'b1;
    flag_clear;
    cpu_write(8'h11);
    check("R8 write ignored when flag clear", cpu_rdata, 8'hC3);
    bus_stop;
  endtask

  task automatic t_nomatch;
    logic ak;
    bus_start;
    send_byte(8'hB6, 1'b0, ak);
    check("R3 no ack", ak, 1'b0);
    check("R3 no flag", irq, 1'b0);
    check("R3 no addr_hit", addr_hit, 1'b0);
    send_byte(8'h55, 1'b0, ak);
    check("R3 data ignored ack", ak, 1'b0);
    check("R3 data ignored flag", irq, 1'b0);
    bus_stop;
  endtask

  task automatic t_gc;
    logic ak;
    set_own(7'h5A, 1'b1);
    bus_start;
    send_byte(8'h00, 1'b0, ak);
    check("R4 gc ack", ak, 1'b1);
    check("R4 gc flag", irq, 1'b1);
    check("R4 gc_hit", gc_hit, 1'b1);
    check("R4 addr_hit", addr_hit, 1'b1);
    flag_clear;
    bus_stop;
    set_own(7'h5A, 1'b0);
    bus_start;
    send_byte(8'h00, 1'b0, ak);
    check("R4 gc disabled nack", ak, 1'b0);
    check("R4 gc disabled flag", irq, 1'b0);
    check("R4 gc disabled gc_hit", gc_hit, 1'b0);
    bus_stop;
  endtask

  task automatic t_ack_off_addr;
    logic ak;
    ack_en = 1'b0;
    bus_start;
    send_byte(8'hB4, 1'b0, ak);
    check("R5 address nack", ak, 1'b0);
    check("R5 no flag", irq, 1'b0);
    check("R5 no addr_hit", addr_hit, 1'b0);
    bus_stop;
    ack_en = 1'b1;
  endtask

  task automatic t_read;
    logic ak;
    logic [7:0] got;
    bus_start;
    send_byte(8'hB5, 1'b0, ak);
    check("R9 read address ack", ak, 1'b1);
    check("R9 slave_tx", slave_tx, 1'b1);
    check("R9 flag", irq, 1'b1);
    cpu_write(8'hA5);
    flag_clear;
    recv_byte(1'b1, 8'h00, got);
    check("R9 transmitted byte", got, 8'hA5);
    check("R9 flag after byte", irq, 1'b1);
    cpu_write(8'hF0);
    flag_clear;
    recv_byte(1'b0, 8'h20, got);
    check("R10 bus byte", got, 8'hD0);
    check("R10 data register holds bus value", cpu_rdata, 8'hD0);
    check("R9 nack leaves tx", slave_tx, 1'b0);
    flag_clear;
    tick(Q);
    check("R9 no drive after nack", sda_drive_low, 1'b0);
    bus_stop;
    check("R11 stop clears slave_tx", slave_tx, 1'b0);
  endtask

  task automatic t_restart;
    logic ak, s;
    bus_start;
    clk_bit(1'b1, s);
    clk_bit(1'b1, s);
    clk_bit(1'b0, s);
    bus_start;
    send_byte(8'hB4, 1'b0, ak);
    check("R11 repeated start ack", ak, 1'b1);
    check("R11 repeated start flag", irq, 1'b1);
    check("R11 address byte", cpu_rdata, 8'hB4);
    flag_clear;
    bus_stop;
    check("R11 stop clears addr_hit", addr_hit, 1'b0);
    check("R11 stop sda released", sda_drive_low, 1'b0);
  endtask

  task automatic t_host;
    logic ak;
    host_mode = 1'b1;
    bus_start;
    send_byte(8'hB4, 1'b0, ak);
    check("R12 host nack", ak, 1'b0);
    check("R12 host no flag", irq, 1'b0);
    check("R12 host no addr_hit", addr_hit, 1'b0);
    bus_stop;
    host_mode = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    report;
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(3);
    t_reset;
    t_write_xfer;
    t_nomatch;
    t_gc;
    t_ack_off_addr;
    t_read;
    t_restart;
    t_host;
    tick(10);
    report;
  end
endmodule